// File: doc/BRIEF.md
# Bidirectional Fault Break Controller

This block combines the fault sources of a PWM timer into one break event per channel. Each channel accepts several internal fault requests, a one-cycle software break strobe, and the sampled level of a shared board fault line. The fault line works both ways. The block reads it as an input and can also pull it low through an open-drain enable. When the pull-down is active, every other device on the line sees the fault.

A break event sets a sticky flag for that channel. It also requests that the main output enable be cleared, and it raises a safe-state request. A line that this block pulls low also reads back low, so the pull-down holds itself on. A disarm bit releases it. The disarm bit is honoured only while the main output enable is already off. The break input path stays active while the channel is disarmed. A lock level freezes the bidirectional enable bits. Two channels with identical logic sit side by side.

Top module: `fbk_ctrl`

## Requirements
- R1: After reset, `pd_en_o`, `brk_flag_o`, `moe_clr_o` and `safe_o` are all 0, bidirectional mode is off and the lock level is 0.
- R2: Internal faults of a channel (bits `c*NSRC` to `c*NSRC+NSRC-1` of `int_fault_i`) are ignored while that channel's break enable is 0. With break enable set, any one of them sets the channel flag and `moe_clr_o` on the next clock edge.
- R3: A software break with break enable 0 sets the channel flag and `moe_clr_o` on the next edge, but never asserts that channel's `pd_en_o`.
- R4: With break enable 1, bidirectional enable 1, active-low polarity (`cfg_pol_hi_i` = 0) and the channel not disarmed, any source (internal, software or the line itself) asserts `pd_en_o` on the next edge. The pull-down then stays asserted until the channel is disarmed.
- R5: While a channel's polarity is active-high (`cfg_pol_hi_i` = 1), its `pd_en_o` is never asserted, and its line level of 1 is treated as the fault.
- R6: The line input passes through two synchronizer flops. An asserted line level sets the flag and `moe_clr_o` on the third clock edge after it is applied.
- R7: A set disarm bit with `moe_i` = 0 releases `pd_en_o` on the next edge. An asserted line level still raises a break event (`moe_clr_o` = 1) while the channel is disarmed.
- R8: The disarm bit has no effect while `moe_i` = 1. An active pull-down remains asserted.
- R9: Once the lock level is non-zero, writes cannot change the bidirectional enable bits, and the lock level can never be lowered. The lock check uses the lock level held before the write.
- R10: A break flag stays set until a one-cycle pulse on `flag_clr_i` clears it. If a new event arrives in the same cycle as the clear, the flag stays set. `safe_o` is 1 whenever any flag is set.
- R11: Clearing the disarm bit re-arms the channel. `pd_en_o` is asserted again one edge later only if a break source is still active.
- R12: Channels are independent. A fault or configuration on one channel leaves the other channel's flag and pull-down unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| int_fault_i | input | NCH*NSRC | Internal fault requests, NSRC per channel |
| sw_brk_i | input | NCH | One-cycle software break strobe per channel |
| pin_i | input | NCH | Raw level sampled from each fault line |
| pd_en_o | output | NCH | Open-drain pull-down enable, 1 pulls the line low |
| cfg_wr_i | input | 1 | Strobe that writes the configuration fields below |
| cfg_brk_en_i | input | NCH | Break enable per channel |
| cfg_bid_i | input | NCH | Bidirectional enable per channel |
| cfg_pol_hi_i | input | NCH | 1 selects active-high line polarity |
| cfg_dsrm_i | input | NCH | Disarm bit per channel |
| cfg_lock_i | input | LOCKW | Requested lock level |
| moe_i | input | 1 | Current main output enable state |
| flag_clr_i | input | NCH | One-cycle clear pulse for each break flag |
| brk_flag_o | output | NCH | Sticky break flag per channel |
| moe_clr_o | output | 1 | Request to clear the main output enable |
| safe_o | output | 1 | Safe-state request, high while any flag is set |

## Verification
The hardest state to reach is the self-held line. In this state the pull-down keeps the line low, the synchronized low level keeps producing a break event, and the only exit is a disarm with the main output enable already off. The bench reproduces it with an open-drain line model that combines `pd_en_o` with an external pull. A single software strobe is enough to latch the line. The bench then tries to disarm with `moe_i` high, repeats the attempt with `moe_i` low, and pulls the line externally while the channel is disarmed. This shows that the input path still sees the fault after the output has been released.

// File: rtl/fbk_pkg.sv
package fbk_pkg;

    // Per-channel configuration held by the register stage
    typedef struct packed {
        logic brk_en;   // break sources other than software are honoured
        logic bid;      // bidirectional (open-drain) drive allowed
        logic pol_hi;   // 1: line level 1 means fault
        logic dsrm;     // disarm request
    } fbk_chcfg_t;

endpackage

// File: rtl/fbk_sync.sv
module fbk_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/fbk_cfg.sv
module fbk_cfg
    import fbk_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned LOCKW = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_i,
    input  logic [NCH-1:0]         brk_en_i,
    input  logic [NCH-1:0]         bid_i,
    input  logic [NCH-1:0]         pol_hi_i,
    input  logic [NCH-1:0]         dsrm_i,
    input  logic [LOCKW-1:0]       lock_i,
    output fbk_chcfg_t [NCH-1:0]   cfg_o,
    output logic [LOCKW-1:0]       lock_o
);

    typedef struct packed {
        fbk_chcfg_t [NCH-1:0] ch;
        logic [LOCKW-1:0]     lock;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            for (int c = 0; c < NCH; c++) begin
                st_d.ch[c].brk_en = brk_en_i[c];
                st_d.ch[c].pol_hi = pol_hi_i[c];
                st_d.ch[c].dsrm   = dsrm_i[c];
                // frozen once any lock level is in force
                if (st_q.lock == '0) begin
                    st_d.ch[c].bid = bid_i[c];
                end
            end
            // lock only ever climbs until reset
            if (lock_i > st_q.lock) begin
                st_d.lock = lock_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.ch;
    assign lock_o = st_q.lock;

endmodule

// File: rtl/fbk_chan.sv
module fbk_chan
    import fbk_pkg::*;
#(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  fbk_chcfg_t      cfg_i,
    input  logic            moe_i,
    input  logic [NSRC-1:0] int_i,
    input  logic            sw_i,
    input  logic            line_i,
    input  logic            flag_clr_i,
    output logic            pd_o,
    output logic            flag_o,
    output logic            evt_o
);

    typedef struct packed {
        logic pd;
        logic flag;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic line_act;
    logic int_any;
    logic hw_src;
    logic drive_ok;
    logic dsrm_eff;
    logic drive_src;

    always_comb begin
        line_act  = cfg_i.pol_hi ? line_i : ~line_i;
        int_any   = |int_i;
        hw_src    = cfg_i.brk_en & (int_any | line_act);
        evt_o     = sw_i | hw_src;
        // open-drain drive only with active-low polarity
        drive_ok  = cfg_i.bid & ~cfg_i.pol_hi;
        // disarm honoured only once outputs are already off
        dsrm_eff  = cfg_i.dsrm & ~moe_i;
        // software break reaches the line only with break enabled
        drive_src = hw_src | (cfg_i.brk_en & sw_i) | st_q.pd;

        st_d.pd   = drive_ok & cfg_i.brk_en & ~dsrm_eff & drive_src;
        st_d.flag = evt_o | (st_q.flag & ~flag_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_o   = st_q.pd;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/fbk_ctrl.sv
module fbk_ctrl
    import fbk_pkg::*;
#(
    parameter int unsigned NCH    = 2,
    parameter int unsigned NSRC   = 3,
    parameter int unsigned LOCKW  = 2,
    parameter int unsigned SYNC_N = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NCH*NSRC-1:0]  int_fault_i,
    input  logic [NCH-1:0]       sw_brk_i,
    input  logic [NCH-1:0]       pin_i,
    output logic [NCH-1:0]       pd_en_o,
    input  logic                 cfg_wr_i,
    input  logic [NCH-1:0]       cfg_brk_en_i,
    input  logic [NCH-1:0]       cfg_bid_i,
    input  logic [NCH-1:0]       cfg_pol_hi_i,
    input  logic [NCH-1:0]       cfg_dsrm_i,
    input  logic [LOCKW-1:0]     cfg_lock_i,
    input  logic                 moe_i,
    input  logic [NCH-1:0]       flag_clr_i,
    output logic [NCH-1:0]       brk_flag_o,
    output logic                 moe_clr_o,
    output logic                 safe_o
);

    typedef struct packed {
        logic moe_clr;
    } top_state_t;

    top_state_t st_d, st_q;

    fbk_chcfg_t [NCH-1:0] cfg_q;
    logic [LOCKW-1:0]     lock_q;
    logic [NCH-1:0]       line_s;
    logic [NCH-1:0]       evt;

    fbk_cfg #(
        .NCH   (NCH),
        .LOCKW (LOCKW)
    ) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (cfg_wr_i),
        .brk_en_i (cfg_brk_en_i),
        .bid_i    (cfg_bid_i),
        .pol_hi_i (cfg_pol_hi_i),
        .dsrm_i   (cfg_dsrm_i),
        .lock_i   (cfg_lock_i),
        .cfg_o    (cfg_q),
        .lock_o   (lock_q)
    );

    fbk_sync #(
        .W       (NCH),
        .STAGES  (SYNC_N),
        .RST_VAL ({NCH{1'b1}})
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (line_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fbk_chan #(
            .NSRC (NSRC)
        ) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cfg_i      (cfg_q[c]),
            .moe_i      (moe_i),
            .int_i      (int_fault_i[c*NSRC +: NSRC]),
            .sw_i       (sw_brk_i[c]),
            .line_i     (line_s[c]),
            .flag_clr_i (flag_clr_i[c]),
            .pd_o       (pd_en_o[c]),
            .flag_o     (brk_flag_o[c]),
            .evt_o      (evt[c])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.moe_clr = |evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign moe_clr_o = st_q.moe_clr;
    assign safe_o    = |brk_flag_o;

endmodule

// File: rtl/fbk_ctrl_chk.sv
module fbk_ctrl_chk
    import fbk_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned NSRC  = 3,
    parameter int unsigned LOCKW = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NCH*NSRC-1:0]  int_fault_i,
    input logic                 moe_i,
    input logic [NCH-1:0]       pd_en_o,
    input logic [NCH-1:0]       flag_clr_i,
    input logic [NCH-1:0]       brk_flag_o,
    input logic                 moe_clr_o,
    input fbk_chcfg_t [NCH-1:0] cfg_i,
    input logic [LOCKW-1:0]     lock_i
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_drive_needs_low_pol_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pd_en_o[c] |-> $past(cfg_i[c].bid && !cfg_i[c].pol_hi));

        assert_dsrm_blocked_by_moe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (moe_i && cfg_i[c].brk_en && cfg_i[c].bid && !cfg_i[c].pol_hi
             && (|int_fault_i[c*NSRC +: NSRC])) |=> pd_en_o[c]);

        assert_int_fault_breaks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_i[c].brk_en && (|int_fault_i[c*NSRC +: NSRC])) |=> (brk_flag_o[c] && moe_clr_o));

        assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (brk_flag_o[c] && !flag_clr_i[c]) |=> brk_flag_o[c]);

        assert_bid_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lock_i != '0) |=> $stable(cfg_i[c].bid));
    end

    assert_lock_no_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_i != '0) |=> (lock_i >= $past(lock_i)));

endmodule

bind fbk_ctrl fbk_ctrl_chk #(
    .NCH   (NCH),
    .NSRC  (NSRC),
    .LOCKW (LOCKW)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .int_fault_i (int_fault_i),
    .moe_i       (moe_i),
    .pd_en_o     (pd_en_o),
    .flag_clr_i  (flag_clr_i),
    .brk_flag_o  (brk_flag_o),
    .moe_clr_o   (moe_clr_o),
    .cfg_i       (cfg_q),
    .lock_i      (lock_q)
);

// File: tb/sim_fbk_ctrl.sv
module sim_fbk_ctrl;

    localparam int unsigned NCH   = 2;
    localparam int unsigned NSRC  = 3;
    localparam int unsigned LOCKW = 2;
    localparam time CLK_PERIOD    = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH*NSRC-1:0] int_fault = '0;
    logic [NCH-1:0]      sw_brk = '0;
    logic [NCH-1:0]      pin;
    logic [NCH-1:0]      pd_en;
    logic                cfg_wr = 1'b0;
    logic [NCH-1:0]      sh_en = '0, sh_bid = '0, sh_pol = '0, sh_dsrm = '0;
    logic [NCH-1:0]      cfg_en = '0, cfg_bid = '0, cfg_pol = '0, cfg_dsrm = '0;
    logic [LOCKW-1:0]    sh_lock = '0, cfg_lock = '0;
    logic                moe = 1'b0;
    logic [NCH-1:0]      flag_clr = '0;
    logic [NCH-1:0]      flag;
    logic                moe_clr;
    logic                safe;

    // board line model: inverted lines idle low and are pulled high by an external fault;
    // normal lines idle high and are pulled low by this block or an external fault
    logic [NCH-1:0] inv_line = '0;
    logic [NCH-1:0] ext_act  = '0;
    assign pin = (inv_line & ext_act) | (~inv_line & ~(pd_en | ext_act));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbk_ctrl #(
        .NCH   (NCH),
        .NSRC  (NSRC),
        .LOCKW (LOCKW)
    ) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .int_fault_i  (int_fault),
        .sw_brk_i     (sw_brk),
        .pin_i        (pin),
        .pd_en_o      (pd_en),
        .cfg_wr_i     (cfg_wr),
        .cfg_brk_en_i (cfg_en),
        .cfg_bid_i    (cfg_bid),
        .cfg_pol_hi_i (cfg_pol),
        .cfg_dsrm_i   (cfg_dsrm),
        .cfg_lock_i   (cfg_lock),
        .moe_i        (moe),
        .flag_clr_i   (flag_clr),
        .brk_flag_o   (flag),
        .moe_clr_o    (moe_clr),
        .safe_o       (safe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write();
        cfg_en   = sh_en;
        cfg_bid  = sh_bid;
        cfg_pol  = sh_pol;
        cfg_dsrm = sh_dsrm;
        cfg_lock = sh_lock;
        cfg_wr   = 1'b1;
        step(1);
        cfg_wr   = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = '1;
        step(1);
        flag_clr = '0;
    endtask

    task automatic t_reset();
        check("R1", "pd_en", 8'(pd_en), 8'h0);
        check("R1", "flag", 8'(flag), 8'h0);
        check("R1", "moe_clr", 8'(moe_clr), 8'h0);
        check("R1", "safe", 8'(safe), 8'h0);
    endtask

    task automatic t_internal();
        int_fault[1] = 1'b1;                 // ch0 source 1, break disabled
        step(2);
        check("R2", "flag ignored", 8'(flag), 8'h0);
        check("R2", "moe_clr ignored", 8'(moe_clr), 8'h0);
        int_fault[1] = 1'b0;
        sh_en[0] = 1'b1;
        cfg_write();
        int_fault[2] = 1'b1;
        step(1);
        check("R2", "flag set", 8'(flag), 8'h1);
        check("R2", "moe_clr set", 8'(moe_clr), 8'h1);
        int_fault[2] = 1'b0;
        step(1);
        check("R2", "moe_clr drop", 8'(moe_clr), 8'h0);
        check("R10", "flag sticky", 8'(flag), 8'h1);
        check("R10", "safe", 8'(safe), 8'h1);
        int_fault[0] = 1'b1;
        flag_clr[0] = 1'b1;
        step(1);
        check("R10", "set wins over clear", 8'(flag), 8'h1);
        int_fault[0] = 1'b0;
        step(1);
        check("R10", "flag after clear", 8'(flag), 8'h0);
        flag_clr[0] = 1'b0;
        check("R10", "safe after clear", 8'(safe), 8'h0);
    endtask

    task automatic t_sw_disabled();
        sh_en[0] = 1'b0; sh_bid[0] = 1'b1; sh_pol[0] = 1'b0;
        cfg_write();
        sw_brk[0] = 1'b1;
        step(1);
        sw_brk[0] = 1'b0;
        check("R3", "flag", 8'(flag), 8'h1);
        check("R3", "moe_clr", 8'(moe_clr), 8'h1);
        check("R3", "pd_en", 8'(pd_en), 8'h0);
        step(3);
        check("R3", "pd_en later", 8'(pd_en), 8'h0);
        clear_flags();
    endtask

    task automatic t_latch_disarm();
        sh_en[0] = 1'b1;
        moe = 1'b1;
        cfg_write();
        sw_brk[0] = 1'b1;
        step(1);
        sw_brk[0] = 1'b0;
        check("R4", "pd_en on sw", 8'(pd_en), 8'h1);
        step(4);
        check("R4", "pd_en held", 8'(pd_en), 8'h1);
        check("R6", "line keeps moe_clr", 8'(moe_clr), 8'h1);
        check("R12", "ch1 flag", 8'(flag[1]), 8'h0);
        sh_dsrm[0] = 1'b1;
        cfg_write();
        step(2);
        check("R8", "disarm with moe set", 8'(pd_en), 8'h1);
        moe = 1'b0;
        step(1);
        check("R7", "disarm releases", 8'(pd_en), 8'h0);
        step(5);
        check("R7", "line idle moe_clr", 8'(moe_clr), 8'h0);
        ext_act[0] = 1'b1;
        step(3);
        check("R6", "line after 3 edges", 8'(moe_clr), 8'h1);
        check("R7", "pd_en while disarmed", 8'(pd_en), 8'h0);
        ext_act[0] = 1'b0;
        step(5);
        sh_dsrm[0] = 1'b0;
        cfg_write();
        step(2);
        check("R11", "rearm no source", 8'(pd_en), 8'h0);
        sh_dsrm[0] = 1'b1;
        cfg_write();
        int_fault[0] = 1'b1;
        step(2);
        check("R7", "disarmed int fault", 8'(pd_en), 8'h0);
        sh_dsrm[0] = 1'b0;
        cfg_write();
        step(1);
        check("R11", "rearm active source", 8'(pd_en), 8'h1);
        int_fault[0] = 1'b0;
        sh_dsrm[0] = 1'b1;
        cfg_write();
        step(1);
        check("R7", "final release", 8'(pd_en), 8'h0);
        step(5);
        clear_flags();
    endtask

    task automatic t_pol_high();
        sh_pol[1] = 1'b1; sh_bid[1] = 1'b1; sh_en[1] = 1'b0;
        cfg_write();
        inv_line[1] = 1'b1;
        step(4);
        clear_flags();
        sh_en[1] = 1'b1;
        cfg_write();
        sw_brk[1] = 1'b1;
        step(1);
        sw_brk[1] = 1'b0;
        check("R5", "pd_en ch1", 8'(pd_en[1]), 8'h0);
        check("R5", "flag ch1", 8'(flag[1]), 8'h1);
        check("R12", "ch0 untouched", 8'({pd_en[0], flag[0]}), 8'h0);
        step(3);
        check("R5", "moe_clr idle", 8'(moe_clr), 8'h0);
        ext_act[1] = 1'b1;
        step(3);
        check("R5", "high line breaks", 8'(moe_clr), 8'h1);
        check("R5", "pd_en never", 8'(pd_en[1]), 8'h0);
        ext_act[1] = 1'b0;
        sh_en[1] = 1'b0;
        cfg_write();
        step(4);
        clear_flags();
    endtask

    task automatic t_lock();
        sh_dsrm[0] = 1'b0;
        sh_lock = 2'd1;
        cfg_write();
        sh_bid[0] = 1'b0;
        sh_lock = 2'd0;
        cfg_write();
        cfg_write();
        sw_brk[0] = 1'b1;
        step(1);
        sw_brk[0] = 1'b0;
        check("R9", "bid frozen by lock", 8'(pd_en[0]), 8'h1);
        sh_dsrm[0] = 1'b1;
        cfg_write();
        step(1);
        check("R9", "cleanup release", 8'(pd_en[0]), 8'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_internal();
        t_sw_disabled();
        t_latch_disarm();
        t_pol_high();
        t_lock();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule